// File: doc/BRIEF.md
# External Interrupt Request Latch

This block captures external interrupt requests on behalf of a small 8-bit processor core. Its main input is an active-low request line, already clean and synchronous to the core clock. Beside it sit four active-high port lines that can be switched in as extra request sources. Inside the block, the main line and the enabled port lines are merged into one active-low trigger. A falling edge on that trigger always records a request. When the level-trigger mode is selected, a low level on the trigger also records one, so several wired-OR sources can share the line. In level mode the request is raised again for as long as any source keeps the line low.

The recorded request sits in a one-bit latch. The latch clears when the core fetches the interrupt vector, so a request that arrives during the service routine is caught afresh. The latch is forwarded to the core as a registered pending signal only while the core's global mask is clear and the block's local enable bit is set. The local enable is written through a one-bit register port. The raw latch value is visible at all times, so software can poll it while the request is masked.

Top module: `xirq_capture`

## Requirements
- R1: While reset is active and on the first clock after it, `req_status`, `irq_pending` and `irq_enable` are 0.
- R2: With `level_mode`=0, a 1-to-0 transition of the merged trigger sets `req_status` on the next clock edge. If the line is simply held low after `vec_fetch` clears the latch, the latch is not set again.
- R3: With `level_mode`=0, a second request is recorded only after the line has returned to 1 and then fallen to 0 again.
- R4: With `level_mode`=1, a low merged trigger sets the latch on every clock edge. A `vec_fetch` while the line is still low therefore leaves `req_status` at 1.
- R5: A `vec_fetch` pulse clears `req_status` at the next clock edge when no new request is being set in the same cycle.
- R6: When a set and a `vec_fetch` clear happen in the same cycle, the set wins and `req_status` stays 1.
- R7: `irq_pending` equals (latch AND NOT `cpu_mask` AND `irq_enable`) as sampled at the previous clock edge. It goes high one cycle after `req_status`.
- R8: Setting `cpu_mask` or clearing the enable drops `irq_pending` but leaves `req_status` unchanged.
- R9: With `port_irq_en`=1, a high level on any bit of `port_pins` pulls the merged trigger low and sets the latch.
- R10: With `port_irq_en`=1 and any port pin high, falls and levels on `irq_pin_n` produce no request. When the port pins go low again while `irq_pin_n` is already low, that also produces no request.
- R11: With `port_irq_en`=0, `port_pins` has no effect on `req_status`.
- R12: A clock edge with `en_wr`=1 loads `en_wdata` into the enable bit, which reads back on `irq_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Main active-low request line, synchronous |
| port_pins | input | 4 | Active-high port request lines |
| port_irq_en | input | 1 | Enables the port lines as request sources |
| level_mode | input | 1 | 0 = falling edge only, 1 = falling edge or low level; static |
| cpu_mask | input | 1 | Global interrupt mask from the core, 1 = masked |
| en_wr | input | 1 | Write strobe for the local enable bit |
| en_wdata | input | 1 | Value written to the local enable bit |
| vec_fetch | input | 1 | Vector fetch strobe, clears the latch |
| irq_pending | output | 1 | Registered request to the core |
| req_status | output | 1 | Raw latch value |
| irq_enable | output | 1 | Readback of the local enable bit |

## Verification
The assertions assume that every input is synchronous to `clk` and settles before the rising edge. They also assume that `level_mode` changes only while the trigger line is idle and the latch holds no request that would be misread. The bench drives every input on the falling clock edge and samples on the falling edge as well. It switches `level_mode` only between scenarios, with the main line high and the port lines low. One flag, armed one cycle after reset, keeps the history-based checks away from values registered during reset.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int unsigned XIRQ_NPORT = 4;

  // Merged active-low trigger: main line low, or any enabled port line high.
  function automatic logic merge_trigger(input logic pin_n,
                                         input logic any_port);
    return pin_n & ~any_port;
  endfunction

  // A falling edge of the merged trigger.
  function automatic logic is_fall(input logic prev_n, input logic cur_n);
    return prev_n & ~cur_n;
  endfunction

  // Set condition of the request latch.
  function automatic logic set_term(input logic fall, input logic lvl,
                                    input logic cur_n);
    return fall | (lvl & ~cur_n);
  endfunction

  // Next latch value: a set takes priority over the vector fetch clear.
  function automatic logic latch_next(input logic cur, input logic set,
                                      input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/xirq_trigger_merge.sv
module xirq_trigger_merge #(
  parameter int unsigned NPORT = xirq_pkg::XIRQ_NPORT
) (
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pins,
  input  logic             port_irq_en,
  output logic             any_port,
  output logic             trig_n
);
  import xirq_pkg::*;

  logic [NPORT-1:0] gated;

  for (genvar g = 0; g < NPORT; g++) begin : g_gate
    assign gated[g] = port_pins[g] & port_irq_en;
  end

  assign any_port = |gated;
  assign trig_n   = merge_trigger(irq_pin_n, any_port);

  // R10: an active port line dominates the main line.
  always_comb begin
    if (any_port) assert_port_masks_pin_R10: assert (!trig_n);
  end

endmodule

// File: rtl/xirq_edge_detect.sv
module xirq_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_n,
  input  logic level_mode,
  output logic fall_evt,
  output logic set_evt
);
  import xirq_pkg::*;

  logic prev_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n <= 1'b1;
    else        prev_n <= trig_n;
  end

  assign fall_evt = is_fall(prev_n, trig_n);
  assign set_evt  = set_term(fall_evt, level_mode, trig_n);

  // R3: two falls cannot follow each other without a return to 1.
  assert_no_back_to_back_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/xirq_req_latch.sv
module xirq_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic vec_fetch,
  output logic latch_q
);
  import xirq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_next(latch_q, set_evt, vec_fetch);
  end

  // R2/R6: a set always leaves the latch at 1.
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> latch_q);
  // R5: a clear with no competing set empties the latch.
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && !set_evt) |=> !latch_q);
  // R8: without a set or a clear the latch holds.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_fetch && !set_evt) |=> $stable(latch_q));

endmodule

// File: rtl/xirq_capture.sv
module xirq_capture #(
  parameter int unsigned NPORT = xirq_pkg::XIRQ_NPORT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pins,
  input  logic             port_irq_en,
  input  logic             level_mode,
  input  logic             cpu_mask,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             vec_fetch,
  output logic             irq_pending,
  output logic             req_status,
  output logic             irq_enable
);

  logic any_port;
  logic trig_n;
  logic fall_evt;
  logic set_evt;
  logic latch_q;
  logic enable_q;
  logic pending_q;
  logic armed_q;

  xirq_trigger_merge #(.NPORT(NPORT)) u_merge (
    .irq_pin_n  (irq_pin_n),
    .port_pins  (port_pins),
    .port_irq_en(port_irq_en),
    .any_port   (any_port),
    .trig_n     (trig_n)
  );

  xirq_edge_detect u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_n    (trig_n),
    .level_mode(level_mode),
    .fall_evt  (fall_evt),
    .set_evt   (set_evt)
  );

  xirq_req_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (set_evt),
    .vec_fetch(vec_fetch),
    .latch_q  (latch_q)
  );

  // R12: local enable register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable_q <= 1'b0;
    else if (en_wr) enable_q <= en_wdata;
  end

  // R7: registered pending output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= latch_q & ~cpu_mask & enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign irq_pending = pending_q;
  assign req_status  = latch_q;
  assign irq_enable  = enable_q;

  // R8: the global mask blocks the pending output.
  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask |=> !irq_pending);
  // R7: a pending request needs an enabled block.
  assert_enable_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |=> !irq_pending);
  // R12: a write is visible on the readback.
  assert_enable_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (irq_enable == $past(en_wdata)));
  // R10: a port line held high for two cycles hides every edge.
  assert_port_hides_edges_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && any_port) |=> !fall_evt);

endmodule

// File: tb/tb_xirq_capture.sv
module tb_xirq_capture;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin_n = 1'b1;
  logic [3:0] port_pins = 4'b0;
  logic       port_irq_en = 1'b0;
  logic       level_mode = 1'b0;
  logic       cpu_mask = 1'b0;
  logic       en_wr = 1'b0;
  logic       en_wdata = 1'b0;
  logic       vec_fetch = 1'b0;
  logic       irq_pending;
  logic       req_status;
  logic       irq_enable;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  xirq_capture dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pins(port_pins),
    .port_irq_en(port_irq_en), .level_mode(level_mode), .cpu_mask(cpu_mask),
    .en_wr(en_wr), .en_wdata(en_wdata), .vec_fetch(vec_fetch),
    .irq_pending(irq_pending), .req_status(req_status), .irq_enable(irq_enable)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_latch();
    vec_fetch = 1'b1; step(); vec_fetch = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 status in reset", req_status, 1'b0);
    check("R1 pending in reset", irq_pending, 1'b0);
    check("R1 enable in reset", irq_enable, 1'b0);
    rst_n = 1'b1; step();
    check("R1 status after reset", req_status, 1'b0);
    check("R1 pending after reset", irq_pending, 1'b0);
  endtask

  task automatic t_enable_write();
    en_wr = 1'b1; en_wdata = 1'b1; step(); en_wr = 1'b0; en_wdata = 1'b0;
    check("R12 enable written", irq_enable, 1'b1);
    step();
    check("R12 enable held", irq_enable, 1'b1);
  endtask

  task automatic t_edge_mode();
    level_mode = 1'b0;
    irq_pin_n = 1'b0; step();
    check("R2 fall sets latch", req_status, 1'b1);
    check("R7 pending lags latch", irq_pending, 1'b0);
    step();
    check("R7 pending follows", irq_pending, 1'b1);
    clear_latch();
    check("R5 vector fetch clears", req_status, 1'b0);
    step(3);
    check("R2 held low no re-request", req_status, 1'b0);
    check("R7 pending dropped", irq_pending, 1'b0);
    irq_pin_n = 1'b1; step();
    check("R3 rise alone no request", req_status, 1'b0);
    irq_pin_n = 1'b0; step();
    check("R3 second fall requests", req_status, 1'b1);
    irq_pin_n = 1'b1; clear_latch(); step();
  endtask

  task automatic t_set_wins();
    irq_pin_n = 1'b0; step();
    irq_pin_n = 1'b1; step();
    check("R6 latch set before", req_status, 1'b1);
    irq_pin_n = 1'b0; vec_fetch = 1'b1; step(); vec_fetch = 1'b0;
    check("R6 set beats clear", req_status, 1'b1);
    irq_pin_n = 1'b1; clear_latch(); step();
    check("R5 cleared", req_status, 1'b0);
  endtask

  task automatic t_mask();
    irq_pin_n = 1'b0; step(); irq_pin_n = 1'b1; step();
    check("R7 pending unmasked", irq_pending, 1'b1);
    cpu_mask = 1'b1; step(2);
    check("R8 mask drops pending", irq_pending, 1'b0);
    check("R8 mask keeps latch", req_status, 1'b1);
    cpu_mask = 1'b0; step(2);
    check("R8 unmask restores pending", irq_pending, 1'b1);
    en_wr = 1'b1; en_wdata = 1'b0; step(); en_wr = 1'b0; step();
    check("R8 disable drops pending", irq_pending, 1'b0);
    check("R8 disable keeps latch", req_status, 1'b1);
    en_wr = 1'b1; en_wdata = 1'b1; step(); en_wr = 1'b0;
    clear_latch(); step();
  endtask

  task automatic t_level_mode();
    level_mode = 1'b1; step();
    irq_pin_n = 1'b0; step();
    check("R4 low level requests", req_status, 1'b1);
    clear_latch();
    check("R4 fetch while low re-requests", req_status, 1'b1);
    step(2);
    check("R4 stays while low", req_status, 1'b1);
    irq_pin_n = 1'b1; clear_latch();
    check("R5 clear after release", req_status, 1'b0);
    step();
    level_mode = 1'b0; step();
  endtask

  task automatic t_ports();
    port_irq_en = 1'b1; port_pins = 4'b0100; step();
    check("R9 port line requests", req_status, 1'b1);
    clear_latch();
    check("R9 cleared with port high", req_status, 1'b0);
    irq_pin_n = 1'b0; step(); irq_pin_n = 1'b1; step(); irq_pin_n = 1'b0; step();
    check("R10 main pin ignored", req_status, 1'b0);
    port_pins = 4'b0000; step(2);
    check("R10 port release while low", req_status, 1'b0);
    irq_pin_n = 1'b1; step();
    port_irq_en = 1'b0; port_pins = 4'b1111; step(2);
    check("R11 disabled ports ignored", req_status, 1'b0);
    port_pins = 4'b0000; step();
  endtask

  initial begin
    step(3);
    t_reset();
    t_enable_write();
    t_edge_mode();
    t_set_wins();
    t_mask();
    t_level_mode();
    t_ports();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule